// File: doc/BRIEF.md
# Programmable periodic interrupt timer

This block is a 16-bit down-counter paced by a programmable prescaler. Software reaches it over a small synchronous register bus: a write strobe, a read strobe and a byte offset that selects one of three halfword registers. The three registers are a control/status word, a modulus and a read-only view of the live count. Each time the count steps past zero it reloads and raises a sticky interrupt flag. A level interrupt line is driven from that flag and its enable bit.

The count can reload in either of two ways: from the modulus, which gives a periodic tick of programmable length, or from the full 16-bit value, which makes a free-running counter. A modulus write can also be made to load the live count at once. A small state machine in the counter core holds the run state. `ST_HALT` is the reset state, and the core leaves it for `ST_RUN` on a re-arming control write that leaves the enable bit set. The core returns from `ST_RUN` to `ST_HALT` on a re-arming control write that clears the enable bit. No other event moves the state.

Top module: `pit_timer`

## Requirements
- R1: After reset, control reads 0x0000, modulus reads 0xFFFF, count reads 0xFFFF, and `irq` is low.
- R2: Offsets 0, 2 and 4 read control, modulus and count. Any other offset reads 0. Control bit positions: enable 0, reload mode 1, flag 2, interrupt enable 3, overwrite 4, debug 5, doze 6, prescale field 11:8. The other control bits read 0.
- R3: While enabled, the count falls by one every 2·2^PRE clocks, where PRE is the prescale field. The first step lands 2·2^PRE clocks after the write that armed it.
- R4: In reload mode, the step after the count reaches 0 loads the modulus and sets the flag.
- R5: With reload mode clear, the step after 0 loads 0xFFFF and sets the flag.
- R6: `irq` is high exactly when the flag and the interrupt enable bit are both set.
- R7: Writing 1 to the flag bit clears the flag. Writing 0 to it leaves the flag as it was. Only an expiry sets it.
- R8: A control write that changes nothing but the interrupt enable bit and the flag does not restart the count or the prescaler.
- R9: Any other control write re-arms the counter: the count loads the modulus in reload mode or 0xFFFF otherwise, the prescaler restarts, and counting proceeds only if enable is set.
- R10: Every modulus write clears the flag.
- R11: With overwrite set, a modulus write loads the count at once and restarts the prescaler. With overwrite clear, the count is untouched and the new modulus is used at the next reload.
- R12: Writes to offset 4 change no register.
- R13: While enable is clear the count holds. The debug and doze bits are stored and read back but change no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; gates `bus_rdata` |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when not reading |
| irq | output | 1 | Level interrupt request |

## Verification
The countdown is driven with a short reload period at the fastest prescale, with a mid-range prescale, and with the slowest prescale of 65536 clocks. Between them, these three separate an off-by-one in the divider from a wrong shift of the prescale field. The free-run case preloads the count through an overwriting modulus write, so the wrap to 0xFFFF is seen without a 65536-step wait. A modulus write without overwrite shows whether the new period is deferred to the next reload. Interrupt-enable-only and flag-only writes are issued mid-period; the next step then lands either on the old schedule or a full period late, which tells a design that restarts the counter from one that does not.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

    // Control word bit positions (software-visible, decoded by the register file)
    localparam int CB_EN    = 0;
    localparam int CB_RLD   = 1;
    localparam int CB_FLAG  = 2;
    localparam int CB_IEN   = 3;
    localparam int CB_OVW   = 4;
    localparam int CB_DBG   = 5;
    localparam int CB_DOZE  = 6;
    localparam int CB_PRE_L = 8;
    localparam int PRE_W    = 4;
    localparam int CB_PRE_H = CB_PRE_L + PRE_W - 1;

    // Prescaler width: largest ratio is 2 * 2^(2^PRE_W - 1)
    localparam int PS_W = 1 << PRE_W;

    // Register byte offsets
    localparam int OFF_CTRL = 0;
    localparam int OFF_MOD  = 2;
    localparam int OFF_CNT  = 4;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             doze;
        logic             dbg;
        logic             ovw;
        logic             ien;
        logic             flag;
        logic             rld;
        logic             en;
    } ctrl_t;

endpackage

// File: rtl/pit_prescale.sv
`timescale 1ns/1ps
module pit_prescale
    import pit_pkg::*;
#(
    parameter int SEL_W = PRE_W,
    parameter int CNT_W = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int SH_W = SEL_W + 1;

    logic [CNT_W-1:0] phase_q;
    logic [CNT_W-1:0] last_phase;
    logic [SH_W-1:0]  shift_amt;

    // Ratio is 2^(sel+1); the last phase value is that minus one.
    always_comb begin
        shift_amt  = {1'b0, sel} + SH_W'(1);
        last_phase = ~({CNT_W{1'b1}} << shift_amt);
    end

    assign tick = run && !restart && (phase_q == last_phase);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || restart || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + CNT_W'(1);
        end
    end

    // R3: a tick always begins a fresh prescale period
    a_r3_tick_wraps_phase: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase_q == '0));

    // R9: a re-arm starts the prescaler from phase zero
    a_r9_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0));

endmodule

// File: rtl/pit_core.sv
`timescale 1ns/1ps
module pit_core
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             arm_en,
    input  logic [CNT_W-1:0] arm_val,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             running
);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             at_zero;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: only a re-arming control write moves the state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (arm && arm_en)  state_d = ST_RUN;
            ST_RUN:  if (arm && !arm_en) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // Outputs and count datapath
    always_comb begin
        running = (state_q == ST_RUN);
        at_zero = (count_q == '0);
        expire  = tick && at_zero && !arm && !ld;
        count_d = count_q;
        if (arm) begin
            count_d = arm_val;
        end else if (ld) begin
            count_d = ld_val;
        end else if (tick) begin
            count_d = at_zero ? reload_val : (count_q - CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '1;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    // R3: the prescaler only ticks a running counter
    a_r3_tick_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (state_q == ST_RUN));

    // R12 / R13: without a tick, re-arm or overwrite the count cannot move
    a_r12_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !arm && !ld) |=> $stable(count_q));

    // R4 / R5: an expiry leaves the count at the reload value
    a_r4_reload_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count_q == $past(reload_val)));

endmodule

// File: rtl/pit_regs.sv
`timescale 1ns/1ps
module pit_regs
    import pit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count,
    input  logic              expire,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic              arm,
    output logic              arm_en,
    output logic [DATA_W-1:0] arm_val,
    output logic              ld,
    output logic [DATA_W-1:0] ld_val,
    output logic [DATA_W-1:0] reload_val
);

    ctrl_t            ctrl_q;
    ctrl_t            wr_view;
    logic [DATA_W-1:0] mod_q;
    logic             wr_ctrl, wr_mod;
    logic             flag_clr;
    logic             cfg_change;

    always_comb begin
        wr_ctrl = wr && (addr == ADDR_W'(OFF_CTRL));
        wr_mod  = wr && (addr == ADDR_W'(OFF_MOD));

        wr_view      = '0;
        wr_view.en   = wdata[CB_EN];
        wr_view.rld  = wdata[CB_RLD];
        wr_view.flag = wdata[CB_FLAG];
        wr_view.ien  = wdata[CB_IEN];
        wr_view.ovw  = wdata[CB_OVW];
        wr_view.dbg  = wdata[CB_DBG];
        wr_view.doze = wdata[CB_DOZE];
        wr_view.pre  = wdata[CB_PRE_H:CB_PRE_L];

        // Anything besides the interrupt bits differing forces a re-arm
        cfg_change = (wr_view.en   != ctrl_q.en)   ||
                     (wr_view.rld  != ctrl_q.rld)  ||
                     (wr_view.ovw  != ctrl_q.ovw)  ||
                     (wr_view.dbg  != ctrl_q.dbg)  ||
                     (wr_view.doze != ctrl_q.doze) ||
                     (wr_view.pre  != ctrl_q.pre);

        flag_clr = (wr_ctrl && wr_view.flag) || wr_mod;

        arm        = wr_ctrl && cfg_change;
        arm_en     = wr_view.en;
        arm_val    = wr_view.rld ? mod_q : '1;
        ld         = wr_mod && ctrl_q.ovw;
        ld_val     = wdata;
        reload_val = ctrl_q.rld ? mod_q : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mod_q  <= '1;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.en   <= wr_view.en;
                ctrl_q.rld  <= wr_view.rld;
                ctrl_q.ien  <= wr_view.ien;
                ctrl_q.ovw  <= wr_view.ovw;
                ctrl_q.dbg  <= wr_view.dbg;
                ctrl_q.doze <= wr_view.doze;
                ctrl_q.pre  <= wr_view.pre;
            end
            if (wr_mod) begin
                mod_q <= wdata;
            end
            if (expire) begin
                ctrl_q.flag <= 1'b1;
            end else if (flag_clr) begin
                ctrl_q.flag <= 1'b0;
            end
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                ADDR_W'(OFF_CTRL): begin
                    rdata[CB_EN]             = ctrl_q.en;
                    rdata[CB_RLD]            = ctrl_q.rld;
                    rdata[CB_FLAG]           = ctrl_q.flag;
                    rdata[CB_IEN]            = ctrl_q.ien;
                    rdata[CB_OVW]            = ctrl_q.ovw;
                    rdata[CB_DBG]            = ctrl_q.dbg;
                    rdata[CB_DOZE]           = ctrl_q.doze;
                    rdata[CB_PRE_H:CB_PRE_L] = ctrl_q.pre;
                end
                ADDR_W'(OFF_MOD): rdata = mod_q;
                ADDR_W'(OFF_CNT): rdata = count;
                default:          rdata = '0;
            endcase
        end
    end

    assign ctrl = ctrl_q;

    // R4 / R5: an expiry always leaves the flag set
    a_r4_expire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ctrl_q.flag);

    // R7: the flag only rises because of an expiry
    a_r7_no_software_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.flag) |-> $past(expire));

    // R10: a modulus write clears the flag unless an expiry coincides
    a_r10_mod_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mod && !expire) |=> !ctrl_q.flag);

    // R12: a write to the count offset leaves the modulus alone
    a_r12_cnt_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(OFF_CNT)) |=> $stable(mod_q));

endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer
    import pit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    ctrl_t             ctrl;
    logic              arm, arm_en, ld, tick, expire, running;
    logic [DATA_W-1:0] arm_val, ld_val, reload_val, count;

    pit_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .count      (count),
        .expire     (expire),
        .rdata      (bus_rdata),
        .ctrl       (ctrl),
        .arm        (arm),
        .arm_en     (arm_en),
        .arm_val    (arm_val),
        .ld         (ld),
        .ld_val     (ld_val),
        .reload_val (reload_val)
    );

    pit_prescale #(
        .SEL_W (PRE_W),
        .CNT_W (PS_W)
    ) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (arm || ld),
        .sel     (ctrl.pre),
        .tick    (tick)
    );

    pit_core #(
        .CNT_W (DATA_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .arm_en     (arm_en),
        .arm_val    (arm_val),
        .ld         (ld),
        .ld_val     (ld_val),
        .tick       (tick),
        .reload_val (reload_val),
        .count      (count),
        .expire     (expire),
        .running    (running)
    );

    assign irq = ctrl.ien && ctrl.flag;

    // R13: the run state follows the enable bit
    a_r13_run_matches_enable: assert property (@(posedge clk) disable iff (!rst_n)
        running == ctrl.en);

endmodule

// File: tb/test_pit_timer.sv
`timescale 1ns/1ps
module test_pit_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pit_timer i_pit_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    localparam logic [2:0] A_CTL = 3'd0;
    localparam logic [2:0] A_MOD = 3'd2;
    localparam logic [2:0] A_CNT = 3'd4;

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%04h expected=0x%04h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #2;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(req, $sformatf("reg@%0d", a), v, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        check(req, "irq", {15'd0, irq}, {15'd0, exp});
    endtask

    task automatic t_reset;
        chk_reg("R1", A_CTL, 16'h0000);
        chk_reg("R1", A_MOD, 16'hFFFF);
        chk_reg("R1", A_CNT, 16'hFFFF);
        chk_irq("R1", 1'b0);
        chk_reg("R2", 3'd6, 16'h0000);
    endtask

    // Prescale 3 -> 16 clocks per step
    task automatic t_rate;
        wr(A_MOD, 16'h0010);
        chk_reg("R11", A_CNT, 16'hFFFF);
        wr(A_CTL, 16'h0303);
        chk_reg("R9", A_CNT, 16'h0010);
        chk_reg("R2", A_CTL, 16'h0303);
        idle(15);
        chk_reg("R3", A_CNT, 16'h0010);
        idle(1);
        chk_reg("R3", A_CNT, 16'h000F);
    endtask

    // Modulus 3, prescale 0: expiry every 8 clocks
    task automatic t_reload;
        wr(A_MOD, 16'h0003);
        wr(A_CTL, 16'h000B);              // edge A
        idle(7);                           // A+7
        chk_reg("R4", A_CNT, 16'h0000);
        chk_irq("R6", 1'b0);
        idle(1);                           // A+8
        chk_reg("R4", A_CNT, 16'h0003);
        chk_irq("R6", 1'b1);
        chk_reg("R4", A_CTL, 16'h000F);
        wr(A_CTL, 16'h000B);              // flag written 0: kept
        chk_irq("R7", 1'b1);
        wr(A_CTL, 16'h000F);              // A+10: flag cleared
        chk_irq("R7", 1'b0);
        chk_reg("R8", A_CNT, 16'h0002);
        idle(6);                           // A+16
        chk_irq("R8", 1'b1);
        wr(A_MOD, 16'h0003);              // A+17
        chk_irq("R10", 1'b0);
        chk_reg("R10", A_CTL, 16'h000B);
        idle(7);                           // A+24
        chk_irq("R8", 1'b1);
        wr(A_CTL, 16'h0003);              // interrupt enable off
        chk_irq("R6", 1'b0);
        chk_reg("R6", A_CTL, 16'h0007);
        wr(A_CTL, 16'h000B);
        chk_irq("R6", 1'b1);
        wr(A_CTL, 16'h0004);              // stop and clear
        chk_irq("R7", 1'b0);
        chk_reg("R9", A_CNT, 16'hFFFF);
    endtask

    task automatic t_freerun;
        wr(A_CTL, 16'h0010);
        wr(A_CTL, 16'h0011);
        wr(A_MOD, 16'h0002);              // edge C
        chk_reg("R11", A_CNT, 16'h0002);
        idle(5);
        chk_reg("R5", A_CNT, 16'h0000);
        chk_reg("R5", A_CTL, 16'h0011);
        idle(1);
        chk_reg("R5", A_CNT, 16'hFFFF);
        chk_reg("R5", A_CTL, 16'h0015);
    endtask

    task automatic t_no_overwrite;
        wr(A_CTL, 16'h0003);              // edge D, count <- 2
        wr(A_MOD, 16'h0004);              // D+1
        chk_reg("R11", A_CNT, 16'h0002);
        idle(4);
        chk_reg("R11", A_CNT, 16'h0000);
        idle(1);
        chk_reg("R11", A_CNT, 16'h0004);
        chk_reg("R4", A_CTL, 16'h0007);
    endtask

    task automatic t_cnt_offset;
        wr(A_CTL, 16'h0004);
        wr(A_CNT, 16'h1234);
        idle(3);
        chk_reg("R12", A_CNT, 16'hFFFF);
        chk_reg("R12", A_CTL, 16'h0000);
        chk_reg("R12", A_MOD, 16'h0004);
    endtask

    task automatic t_halt_bits;
        wr(A_CTL, 16'hF0E0);
        chk_reg("R2", A_CTL, 16'h0060);
        idle(20);
        chk_reg("R13", A_CNT, 16'hFFFF);
        wr(A_CTL, 16'h0063);              // edge E
        chk_reg("R13", A_CNT, 16'h0004);
        idle(2);
        chk_reg("R13", A_CNT, 16'h0003);
    endtask

    task automatic t_max_prescale;
        wr(A_CTL, 16'h0F03);              // ratio 65536
        chk_reg("R9", A_CNT, 16'h0004);
        idle(65535);
        chk_reg("R3", A_CNT, 16'h0004);
        idle(1);
        chk_reg("R3", A_CNT, 16'h0003);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_rate();
        t_reload();
        t_freerun();
        t_no_overwrite();
        t_cnt_offset();
        t_halt_bits();
        t_max_prescale();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (R1..all): actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule